// File: doc/BRIEF.md
# Host-Side Byte FIFO with Command Capture

This block sits between a host register port and a storage-bus data path. Host writes to the FIFO data register either fill a small byte queue or, while a select-and-hold command is pending, fill a separate command buffer instead. Host reads drain the queue in arrival order. A signed pending-transfer count tracks how many bytes the queue holds. Once the queue empties, both pointers go back to slot zero, so the full depth is available again.

Two side operations complete the block. The first loads a two-byte status response (the status byte, then a zero byte) and sets the flags register to 2. The second takes the queued bytes out as a command: it copies them into the command buffer, swaps the lead byte for byte 2 shifted right by five, and empties the queue. Every accepted read and every status load sends a one-cycle interrupt request to the interrupt unit.

Top module: `hostq_cmd_fifo`

## Requirements
- R1: After synchronous reset, `host_rdata`, `irq`, `pend_count`, `fifo_flags` and `cmd_len` are all zero.
- R2: With `cmd_mode` low, a host write stores the byte and adds one to `pend_count`. The write is dropped when the write pointer sits at FIFO_DEPTH-1, so an empty queue takes at most 15 bytes at the default depth of 16.
- R3: A host read while `pio_phase` is 3'b000 puts 8'h00 on `host_rdata`, pulses `irq`, and leaves the queue contents and `pend_count` unchanged.
- R4: A host read while `pio_phase` is non-zero and the queue holds data returns the oldest byte on `host_rdata`. The same cycle subtracts one from `pend_count` and pulses `irq`. All three effects are visible in the cycle after the read strobe.
- R5: A host read while `pio_phase` is non-zero and the queue is empty leaves `host_rdata` and `pend_count` unchanged and raises no `irq`.
- R6: When a read consumes the last queued byte, both pointers return to zero. While the queue is not empty, the pointers keep their place, so capacity that reads have freed is not reusable until the queue drains.
- R7: With `cmd_mode` high, a host write goes to command-buffer entry `cmd_len` and adds one to `cmd_len`, leaving the queue untouched. Once `cmd_len` reaches CMD_DEPTH (32), further writes are dropped.
- R8: A status load makes the next cycle show `pend_count` = 2, `fifo_flags` = 2 and an `irq` pulse. The next two reads return the status byte and then 8'h00.
- R9: A command take sets `cmd_len` to `pend_count`. It copies queue slots 1..n-1 into command entries 1..n-1, sets entry 0 to queue slot 2 shifted right by 5, and empties the queue with `pend_count` = 0.
- R10: When strobes coincide, only one takes effect, in the priority order status load, command take, read, write. The others are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe to the FIFO data register |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe from the FIFO data register |
| host_rdata | output | 8 | Last byte returned by a host read |
| cmd_mode | input | 1 | High while host writes go to the command buffer |
| pio_phase | input | 3 | Programmed-I/O phase bits; all zero means data-out |
| sts_load | input | 1 | Load the two-byte status response |
| sts_byte | input | 8 | Status byte for the response |
| cmd_take | input | 1 | Take the queued bytes out as a command |
| cmd_idx | input | 5 | Command buffer read index |
| cmd_byte | output | 8 | Command buffer entry at `cmd_idx` |
| cmd_len | output | 6 | Number of valid command bytes |
| pend_count | output | 6 | Signed pending-transfer count |
| fifo_flags | output | 8 | FIFO flags register |
| irq | output | 1 | One-cycle interrupt request |

## Verification
A write pointer that has drifted from the data shows up within a single read, either as a byte returned out of order or as a `pend_count` that disagrees with the number of bytes actually returned. A pointer that fails to reset on drain stays hidden until the next fill, when writes are refused before 15 bytes are in. The bench therefore refills after every drain. A wrong command-capture index corrupts command entries, which the bench reads back through `cmd_idx` right after the capture. Priority errors show in the cycle after the coinciding strobes, through `pend_count` and `cmd_len`.

// File: rtl/hostq_pkg.sv
package hostq_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_STATUS,
        OP_TAKE,
        OP_READ,
        OP_WRITE,
        OP_CAPTURE
    } op_e;

    // Lead command byte is rebuilt from the third queued byte
    function automatic byte_t lead_fix(byte_t third);
        return third >> 5;
    endfunction

endpackage

// File: rtl/hostq_op_arb.sv
module hostq_op_arb
    import hostq_pkg::*;
(
    input  logic sts_load,
    input  logic cmd_take,
    input  logic host_rd,
    input  logic host_wr,
    input  logic cmd_mode,
    output op_e  op
);

    always_comb begin
        if (sts_load)
            op = OP_STATUS;
        else if (cmd_take)
            op = OP_TAKE;
        else if (host_rd)
            op = OP_READ;
        else if (host_wr)
            op = cmd_mode ? OP_CAPTURE : OP_WRITE;
        else
            op = OP_IDLE;
    end

endmodule

// File: rtl/hostq_data_fifo.sv
module hostq_data_fifo
    import hostq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  op_e                     op,
    input  byte_t                   wdata,
    input  byte_t                   sts_byte,
    input  logic [2:0]              pio_phase,
    output byte_t                   rdata,
    output logic                    irq,
    output logic signed [CNT_W-1:0] count,
    output byte_t                   flags,
    output logic [DEPTH-1:0][BYTE_W-1:0] slots
);

    localparam int PW = $clog2(DEPTH);
    localparam logic [PW-1:0] LAST_W = PW'(DEPTH - 1);

    logic [DEPTH-1:0][BYTE_W-1:0] mem;
    logic [PW-1:0]                rptr, wptr;
    logic signed [CNT_W-1:0]      cnt;
    byte_t                        rdata_q, flags_q;
    logic                         irq_q;
    logic                         has_data;
    logic                         last_byte;

    assign has_data  = rptr < wptr;
    assign last_byte = (rptr + PW'(1)) == wptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem     <= '0;
            rptr    <= '0;
            wptr    <= '0;
            cnt     <= '0;
            rdata_q <= '0;
            flags_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (op)
                OP_STATUS: begin
                    mem[0]  <= sts_byte;
                    mem[1]  <= '0;
                    rptr    <= '0;
                    wptr    <= PW'(2);
                    cnt     <= CNT_W'(2);
                    flags_q <= 8'd2;
                    irq_q   <= 1'b1;
                end
                OP_TAKE: begin
                    rptr <= '0;
                    wptr <= '0;
                    cnt  <= '0;
                end
                OP_READ: begin
                    if (pio_phase == 3'b000) begin
                        rdata_q <= '0;
                        irq_q   <= 1'b1;
                        if (!has_data) begin
                            rptr <= '0;
                            wptr <= '0;
                        end
                    end else if (has_data) begin
                        rdata_q <= mem[rptr];
                        cnt     <= cnt - CNT_W'(1);
                        irq_q   <= 1'b1;
                        if (last_byte) begin
                            rptr <= '0;
                            wptr <= '0;
                        end else begin
                            rptr <= rptr + PW'(1);
                        end
                    end else begin
                        rptr <= '0;
                        wptr <= '0;
                    end
                end
                OP_WRITE: begin
                    if (wptr != LAST_W) begin
                        mem[wptr] <= wdata;
                        wptr      <= wptr + PW'(1);
                        cnt       <= cnt + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign rdata = rdata_q;
    assign irq   = irq_q;
    assign count = cnt;
    assign flags = flags_q;
    assign slots = mem;

    // R2: a write at the last pointer position changes nothing
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WRITE && wptr == LAST_W) |=> (wptr == LAST_W && cnt == $past(cnt)));

    // R4: read pointer never passes the write pointer
    a_r4_ptr_order: assert property (@(posedge clk) disable iff (rst)
        rptr <= wptr);

    // R4: pending count equals the occupied span
    a_r4_count_span: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) == int'(wptr) - int'(rptr));

    // R6: draining the last byte returns both pointers to zero
    a_r6_drain_zero: assert property (@(posedge clk) disable iff (rst)
        (op == OP_READ && pio_phase != 3'b000 && has_data && last_byte)
        |=> (rptr == '0 && wptr == '0));

    // R8: status load yields count 2, flags 2 and an interrupt
    a_r8_status_load: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STATUS) |=> (cnt == CNT_W'(2) && flags_q == 8'd2 && irq_q));

endmodule

// File: rtl/hostq_cmd_store.sv
module hostq_cmd_store
    import hostq_pkg::*;
#(
    parameter int CMD_DEPTH  = 32,
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 6,
    parameter int LEN_W      = 6,
    parameter int IDX_W      = 5
) (
    input  logic                             clk,
    input  logic                             rst,
    input  op_e                              op,
    input  byte_t                            wdata,
    input  logic [FIFO_DEPTH-1:0][BYTE_W-1:0] slots,
    input  logic signed [CNT_W-1:0]          fifo_count,
    input  logic [IDX_W-1:0]                 rd_idx,
    output byte_t                            rd_byte,
    output logic [LEN_W-1:0]                 len
);

    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(CMD_DEPTH);

    byte_t            cbuf [CMD_DEPTH];
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] take_len;
    logic             cap_ok;

    assign take_len = (fifo_count < 0) ? '0 : LEN_W'(fifo_count);
    assign cap_ok   = (op == OP_CAPTURE) && (len_q < FULL_LEN);

    for (genvar g = 0; g < CMD_DEPTH; g++) begin : g_entry
        byte_t take_src;
        if (g == 0) begin : g_lead
            assign take_src = lead_fix(slots[2]);
        end else if (g < FIFO_DEPTH) begin : g_copy
            assign take_src = slots[g];
        end else begin : g_keep
            assign take_src = cbuf[g];
        end

        always_ff @(posedge clk) begin
            if (rst)
                cbuf[g] <= '0;
            else if (op == OP_TAKE)
                cbuf[g] <= take_src;
            else if (cap_ok && len_q == LEN_W'(g))
                cbuf[g] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            len_q <= '0;
        else if (op == OP_TAKE)
            len_q <= take_len;
        else if (cap_ok)
            len_q <= len_q + LEN_W'(1);
    end

    assign rd_byte = cbuf[rd_idx];
    assign len     = len_q;

    // R7: command length never exceeds the buffer size
    a_r7_len_bound: assert property (@(posedge clk) disable iff (rst)
        len_q <= FULL_LEN);

    // R7: an accepted capture advances the length by one
    a_r7_capture_step: assert property (@(posedge clk) disable iff (rst)
        cap_ok |=> (len_q == $past(len_q) + LEN_W'(1)));

    // R9: a take loads the queued count as the command length
    a_r9_take_len: assert property (@(posedge clk) disable iff (rst)
        (op == OP_TAKE) |=> (len_q == $past(take_len)));

endmodule

// File: rtl/hostq_cmd_fifo.sv
module hostq_cmd_fifo
    import hostq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CMD_DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    input  logic              host_rd,
    output logic [7:0]        host_rdata,
    input  logic              cmd_mode,
    input  logic [2:0]        pio_phase,
    input  logic              sts_load,
    input  logic [7:0]        sts_byte,
    input  logic              cmd_take,
    input  logic [4:0]        cmd_idx,
    output logic [7:0]        cmd_byte,
    output logic [5:0]        cmd_len,
    output logic signed [5:0] pend_count,
    output logic [7:0]        fifo_flags,
    output logic              irq
);

    localparam int CNT_W = $clog2(FIFO_DEPTH) + 2;
    localparam int LEN_W = $clog2(CMD_DEPTH + 1);
    localparam int IDX_W = $clog2(CMD_DEPTH);

    op_e                          op;
    logic signed [CNT_W-1:0]      count;
    logic [FIFO_DEPTH-1:0][BYTE_W-1:0] slots;
    logic [LEN_W-1:0]             len;
    byte_t                        rdata, flags, cbyte;
    logic                         irq_w;

    hostq_op_arb u_arb (
        .sts_load (sts_load),
        .cmd_take (cmd_take),
        .host_rd  (host_rd),
        .host_wr  (host_wr),
        .cmd_mode (cmd_mode),
        .op       (op)
    );

    hostq_data_fifo #(
        .DEPTH (FIFO_DEPTH),
        .CNT_W (CNT_W)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .wdata     (host_wdata),
        .sts_byte  (sts_byte),
        .pio_phase (pio_phase),
        .rdata     (rdata),
        .irq       (irq_w),
        .count     (count),
        .flags     (flags),
        .slots     (slots)
    );

    hostq_cmd_store #(
        .CMD_DEPTH  (CMD_DEPTH),
        .FIFO_DEPTH (FIFO_DEPTH),
        .CNT_W      (CNT_W),
        .LEN_W      (LEN_W),
        .IDX_W      (IDX_W)
    ) u_cmd (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .wdata      (host_wdata),
        .slots      (slots),
        .fifo_count (count),
        .rd_idx     (IDX_W'(cmd_idx)),
        .rd_byte    (cbyte),
        .len        (len)
    );

    assign host_rdata = rdata;
    assign fifo_flags = flags;
    assign irq        = irq_w;
    assign cmd_byte   = cbyte;
    assign cmd_len    = 6'(len);
    assign pend_count = 6'(count);

    // R3: an interrupt pulse only follows a read or a status load
    a_r3_irq_cause: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(host_rd || sts_load));

    // R10: a status load suppresses any coinciding capture
    a_r10_status_wins: assert property (@(posedge clk) disable iff (rst)
        (sts_load && host_wr && cmd_mode) |=> $stable(cmd_len));

endmodule

// File: tb/hostq_cmd_fifo_tb_top.sv
`timescale 1ns/1ps
module hostq_cmd_fifo_tb_top;

    localparam int FD = 16;
    localparam int CD = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic              host_wr, host_rd, cmd_mode, sts_load, cmd_take;
    logic [7:0]        host_wdata, host_rdata, sts_byte, cmd_byte, fifo_flags;
    logic [2:0]        pio_phase;
    logic [4:0]        cmd_idx;
    logic [5:0]        cmd_len;
    logic signed [5:0] pend_count;
    logic              irq;

    always #2 clk = ~clk;

    hostq_cmd_fifo dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .cmd_mode(cmd_mode),
        .pio_phase(pio_phase), .sts_load(sts_load), .sts_byte(sts_byte),
        .cmd_take(cmd_take), .cmd_idx(cmd_idx), .cmd_byte(cmd_byte),
        .cmd_len(cmd_len), .pend_count(pend_count), .fifo_flags(fifo_flags),
        .irq(irq)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] mm [FD];
    logic [7:0] cm [CD];
    int mw = 0, mr = 0, mc = 0, cl = 0;
    logic [7:0] last_rd = 8'h00;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input bit w, r, s, t, input logic [7:0] wd, sb);
        @(negedge clk);
        host_wr = w; host_rd = r; sts_load = s; cmd_take = t;
        host_wdata = wd; sts_byte = sb;
        @(negedge clk);
        host_wr = 0; host_rd = 0; sts_load = 0; cmd_take = 0;
    endtask

    task automatic do_write(input logic [7:0] b, input string req);
        step(1, 0, 0, 0, b, 8'h00);
        if (cmd_mode) begin
            if (cl < CD) begin cm[cl] = b; cl++; end
            chk(req, int'(cmd_len), cl);
        end else if (mw != FD - 1) begin
            mm[mw] = b; mw++; mc++;
        end
        chk(req, int'(pend_count), mc);
        chk(req, int'(irq), 0);
    endtask

    task automatic do_read(input string req);
        step(0, 1, 0, 0, 8'h00, 8'h00);
        if (pio_phase == 3'b000) begin
            last_rd = 8'h00;
            chk(req, int'(host_rdata), 0);
            chk(req, int'(irq), 1);
            if (mr == mw) begin mr = 0; mw = 0; end
        end else if (mr < mw) begin
            last_rd = mm[mr]; mr++; mc--;
            chk(req, int'(host_rdata), int'(last_rd));
            chk(req, int'(irq), 1);
            if (mr == mw) begin mr = 0; mw = 0; end
        end else begin
            chk(req, int'(host_rdata), int'(last_rd));
            chk(req, int'(irq), 0);
            mr = 0; mw = 0;
        end
        chk(req, int'(pend_count), mc);
    endtask

    task automatic do_take(input string req);
        step(0, 0, 0, 1, 8'h00, 8'h00);
        for (int i = 0; i < FD; i++) cm[i] = (i == 0) ? (mm[2] >> 5) : mm[i];
        cl = mc; mc = 0; mr = 0; mw = 0;
        chk(req, int'(cmd_len), cl);
        chk(req, int'(pend_count), 0);
        for (int i = 0; i < cl; i++) begin
            cmd_idx = 5'(i); #0.1;
            chk(req, int'(cmd_byte), int'(cm[i]));
        end
    endtask

    task automatic do_status(input logic [7:0] sb, input string req);
        step(0, 0, 1, 0, 8'h00, sb);
        mm[0] = sb; mm[1] = 8'h00; mr = 0; mw = 2; mc = 2;
        chk(req, int'(pend_count), 2);
        chk(req, int'(fifo_flags), 2);
        chk(req, int'(irq), 1);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hang expected finish");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < FD; i++) mm[i] = 8'h00;
        for (int i = 0; i < CD; i++) cm[i] = 8'h00;
        rst = 1; host_wr = 0; host_rd = 0; sts_load = 0; cmd_take = 0;
        cmd_mode = 0; pio_phase = 3'b001; host_wdata = 0; sts_byte = 0; cmd_idx = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1", int'(host_rdata), 0);
        chk("R1", int'(irq), 0);
        chk("R1", int'(pend_count), 0);
        chk("R1", int'(fifo_flags), 0);
        chk("R1", int'(cmd_len), 0);

        // R5 empty read raises nothing
        do_read("R5");

        // R3 data-out phase reads, empty then filled
        pio_phase = 3'b000;
        do_read("R3");
        for (int k = 0; k < 3; k++) do_write(8'(8'h30 + k), "R2");
        do_read("R3");
        do_read("R3");
        pio_phase = 3'b001;
        for (int k = 0; k < 3; k++) do_read("R4");

        // R2 R4 R6 fill levels 1..15, every non-zero phase value
        for (int n = 1; n < FD; n++) begin
            pio_phase = 3'((n % 7) + 1);
            for (int k = 0; k < n; k++) do_write(8'((n * 37 + k * 11 + 5) & 255), "R2");
            for (int k = 0; k < n; k++) do_read("R4");
            chk("R6", int'(pend_count), 0);
        end

        // R2 overflow: only 15 bytes accepted from empty
        for (int k = 0; k < 20; k++) do_write(8'(8'hA0 + k), "R2");
        chk("R2", int'(pend_count), FD - 1);
        for (int k = 0; k < FD - 1; k++) do_read("R4");
        do_read("R5");
        do_read("R5");

        // R6 freed space not reused before drain
        for (int k = 0; k < 10; k++) do_write(8'(8'h50 + k), "R6");
        for (int k = 0; k < 5; k++) do_read("R6");
        for (int k = 0; k < 10; k++) do_write(8'(8'h70 + k), "R6");
        chk("R6", int'(pend_count), 10);
        for (int k = 0; k < 10; k++) do_read("R6");
        for (int k = 0; k < FD - 1; k++) do_write(8'(8'hC0 + k), "R6");
        chk("R6", int'(pend_count), FD - 1);
        for (int k = 0; k < FD - 1; k++) do_read("R6");

        // R7 command capture with overrun
        cmd_mode = 1;
        for (int k = 0; k < CD + 3; k++) do_write(8'((k * 29 + 3) & 255), "R7");
        chk("R7", int'(cmd_len), CD);
        for (int i = 0; i < CD; i++) begin
            cmd_idx = 5'(i); #0.1;
            chk("R7", int'(cmd_byte), int'(cm[i]));
        end
        cmd_mode = 0;

        // R9 command take over several lead patterns
        for (int p = 0; p < 4; p++) begin
            int n;
            n = 3 + p * 3;
            for (int k = 0; k < n; k++)
                do_write((k == 2) ? 8'(8'hE0 - p * 8'h45) : 8'(p * 16 + k), "R9");
            do_take("R9");
            do_read("R9");
        end

        // R8 status response
        do_status(8'h42, "R8");
        do_read("R8");
        do_read("R8");
        do_read("R8");

        // R10 priority: status wins over all
        cmd_mode = 1;
        step(1, 1, 1, 1, 8'h99, 8'h17);
        mm[0] = 8'h17; mm[1] = 8'h00; mr = 0; mw = 2; mc = 2;
        chk("R10", int'(pend_count), 2);
        chk("R10", int'(cmd_len), cl);
        // take wins over read and capture
        step(1, 1, 0, 1, 8'h99, 8'h00);
        for (int i = 0; i < FD; i++) cm[i] = (i == 0) ? (mm[2] >> 5) : mm[i];
        cl = 2; mc = 0; mr = 0; mw = 0;
        chk("R10", int'(cmd_len), 2);
        chk("R10", int'(pend_count), 0);
        chk("R10", int'(irq), 0);
        cmd_mode = 0;
        // read wins over write
        for (int k = 0; k < 3; k++) do_write(8'(8'h61 + k), "R10");
        step(1, 1, 0, 0, 8'hEE, 8'h00);
        last_rd = mm[mr]; mr++; mc--;
        chk("R10", int'(host_rdata), int'(last_rd));
        chk("R10", int'(pend_count), 2);
        do_read("R10");
        do_read("R10");
        do_read("R10");

        done = 1;
        finish_run();
    end

endmodule